// File: doc/BRIEF.md
# Multi-Channel Idle Power-Down Detector

This block watches a group of serial channels and tells software when the whole group has gone quiet long enough to be powered down. Each channel supplies three status lines: an interrupt-pending flag, a transmitter-idle flag and a receiver-idle flag. A channel is quiet only when nothing is pending and both directions are idle. The group is quiet only when every channel is quiet in the same cycle.

A 2-bit filter code selects one of three debounce windows, or turns the feature off. When the group has been quiet for a whole window, a sticky request bit is set. A software read of the status register clears it. A mask bit routes the request to an interrupt line. The request shares one status bit position with a general-purpose input: while the feature is off, that position shows the input pin instead. The block only reports readiness. It never changes a power state on its own.

Top module: `pdn_idle_detect`

## Requirements
- R1: A channel is quiet only when its interrupt-pending input is 0 and its transmitter-idle and receiver-idle inputs are both 1. Any one of the three lines alone keeps the request from being set.
- R2: A request can be set only in a cycle in which all NUM_CH channels are quiet at the same time.
- R3: Let N be the selected window. The request bit reads 1 after the N-th consecutive rising edge at which all channels are quiet, and reads 0 after N-1 such edges. Any non-quiet cycle restarts the count from zero.
- R4: Filter code 2'b00 disables request generation: the request stays 0 and the interrupt output stays 0 no matter how long the channels stay quiet.
- R5: Once set, the request bit holds through later channel activity. It clears on the rising edge at which the read strobe is 1.
- R6: The interrupt output equals the request bit AND the mask input. With the mask at 0, the interrupt stays 0.
- R7: The shared status output shows the request bit while the filter code is non-zero, and shows the general-purpose input while the code is 2'b00.
- R8: Filter codes 2'b01, 2'b10 and 2'b11 select windows of TERM_A, TERM_B and TERM_C cycles, in increasing order.
- R9: If a read strobe lands in the same cycle that a new request fires, the request bit is left set.
- R10: An unbroken quiet stretch produces at most one request. After that request is read and cleared, the bit stays 0 until some channel has been active and the full window has passed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_irq_pend | input | NUM_CH | Per-channel interrupt-pending flag |
| ch_tx_idle | input | NUM_CH | Per-channel transmitter-idle flag |
| ch_rx_idle | input | NUM_CH | Per-channel receiver-idle flag |
| filt_code | input | 2 | Filter window select; 2'b00 turns the feature off |
| irq_mask | input | 1 | Routes the request to the interrupt output when 1 |
| status_rd | input | 1 | One-cycle strobe for a software read of the status register |
| gp_in | input | 1 | General-purpose input shown on the shared position when disabled |
| stat_bit | output | 1 | Shared status bit: request or general-purpose input |
| pd_irq | output | 1 | Power-down interrupt |

## Verification
The bench times each window edge by edge, checking one cycle before the expected set and on it. A counter that is one cycle off, or that fails to restart after a short burst of activity, fails those checks. It drives each of the three per-channel lines alone, on single channels, so that an aggregation that ignores a line or a channel sets the request where it must not. It lands a read on the exact cycle a request fires, where clear-over-set priority would lose the request. It also reads while the channels stay quiet, where a counter that re-arms would set the bit a second time.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
   typedef enum logic [1:0] {
      FILT_OFF   = 2'b00,
      FILT_SHORT = 2'b01,
      FILT_MID   = 2'b10,
      FILT_LONG  = 2'b11
   } filt_code_e;
endpackage

// File: rtl/pdn_quiet_agg.sv
module pdn_quiet_agg #(
   parameter int NUM_CH = 4
) (
   input  logic [NUM_CH-1:0] ch_irq_pend,
   input  logic [NUM_CH-1:0] ch_tx_idle,
   input  logic [NUM_CH-1:0] ch_rx_idle,
   output logic              all_quiet
);
   logic [NUM_CH-1:0] ch_quiet;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign ch_quiet[i] = ~ch_irq_pend[i] & ch_tx_idle[i] & ch_rx_idle[i];
   end

   assign all_quiet = &ch_quiet;
endmodule

// File: rtl/pdn_window_timer.sv
module pdn_window_timer
   import pdn_pkg::*;
#(
   parameter int TERM_A = 1024,
   parameter int TERM_B = 16384,
   parameter int TERM_C = 262144,
   localparam int CNT_W = $clog2(TERM_C + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       all_quiet,
   input  filt_code_e code,
   output logic       fire
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term_m1;
   logic             fired_q;
   logic             en;

   assign en = (code != FILT_OFF);

   always_comb begin
      unique case (code)
         FILT_SHORT: term_m1 = CNT_W'(TERM_A - 1);
         FILT_MID:   term_m1 = CNT_W'(TERM_B - 1);
         FILT_LONG:  term_m1 = CNT_W'(TERM_C - 1);
         default:    term_m1 = '0;
      endcase
   end

   assign fire = en & all_quiet & ~fired_q & (cnt_q >= term_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else if (!en || !all_quiet) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else begin
         if (!fired_q && (cnt_q < term_m1)) cnt_q <= cnt_q + 1'b1;
         if (fire) fired_q <= 1'b1;
      end
   end
endmodule

// File: rtl/pdn_sticky_stat.sv
module pdn_sticky_stat (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic fire,
   input  logic status_rd,
   input  logic irq_mask,
   input  logic gp_in,
   output logic stat_q,
   output logic stat_bit,
   output logic pd_irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= 1'b0;
      else        stat_q <= en & (fire | (stat_q & ~status_rd));
   end

   assign stat_bit = en ? stat_q : gp_in;
   assign pd_irq   = stat_q & irq_mask;
endmodule

// File: rtl/pdn_idle_detect.sv
module pdn_idle_detect
   import pdn_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int TERM_A = 1024,
   parameter int TERM_B = 16384,
   parameter int TERM_C = 262144
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_irq_pend,
   input  logic [NUM_CH-1:0] ch_tx_idle,
   input  logic [NUM_CH-1:0] ch_rx_idle,
   input  logic [1:0]        filt_code,
   input  logic              irq_mask,
   input  logic              status_rd,
   input  logic              gp_in,
   output logic              stat_bit,
   output logic              pd_irq
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("pdn_idle_detect: NUM_CH must be at least 1");
   end
   if (TERM_A < 1) begin : g_bad_a
      $error("pdn_idle_detect: TERM_A must be at least 1");
   end
   if (!(TERM_A < TERM_B && TERM_B < TERM_C)) begin : g_bad_order
      $error("pdn_idle_detect: windows must increase A < B < C");
   end

   filt_code_e code;
   logic       all_quiet;
   logic       timer_fire;
   logic       stat_q;

   assign code = filt_code_e'(filt_code);

   pdn_quiet_agg #(.NUM_CH(NUM_CH)) u_agg (
      .ch_irq_pend(ch_irq_pend),
      .ch_tx_idle (ch_tx_idle),
      .ch_rx_idle (ch_rx_idle),
      .all_quiet  (all_quiet)
   );

   pdn_window_timer #(.TERM_A(TERM_A), .TERM_B(TERM_B), .TERM_C(TERM_C)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .all_quiet(all_quiet),
      .code     (code),
      .fire     (timer_fire)
   );

   pdn_sticky_stat u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (code != FILT_OFF),
      .fire     (timer_fire),
      .status_rd(status_rd),
      .irq_mask (irq_mask),
      .gp_in    (gp_in),
      .stat_q   (stat_q),
      .stat_bit (stat_bit),
      .pd_irq   (pd_irq)
   );
endmodule

// File: rtl/pdn_idle_detect_chk.sv
module pdn_idle_detect_chk #(
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ch_irq_pend,
   input logic [NUM_CH-1:0] ch_tx_idle,
   input logic [NUM_CH-1:0] ch_rx_idle,
   input logic [1:0]        filt_code,
   input logic              irq_mask,
   input logic              status_rd,
   input logic              gp_in,
   input logic              stat_bit,
   input logic              pd_irq,
   input logic              stat_q,
   input logic              timer_fire
);
   logic quiet_p;
   assign quiet_p = (ch_irq_pend == '0) && (ch_tx_idle == '1) && (ch_rx_idle == '1);

   p_set_needs_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q) |-> $past(quiet_p && filt_code != 2'b00));

   p_off_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_code == 2'b00 && $past(filt_code) == 2'b00) |-> !pd_irq);

   p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q && !status_rd && filt_code != 2'b00) |=> (stat_q || filt_code == 2'b00));

   p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !timer_fire) |=> !stat_q);

   p_mask_gates_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_mask |-> !pd_irq);

   p_gp_shown_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_code == 2'b00) |-> (stat_bit == gp_in));

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_fire && status_rd && filt_code != 2'b00) |=> stat_q);
endmodule

bind pdn_idle_detect pdn_idle_detect_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ch_irq_pend(ch_irq_pend),
   .ch_tx_idle (ch_tx_idle),
   .ch_rx_idle (ch_rx_idle),
   .filt_code  (filt_code),
   .irq_mask   (irq_mask),
   .status_rd  (status_rd),
   .gp_in      (gp_in),
   .stat_bit   (stat_bit),
   .pd_irq     (pd_irq),
   .stat_q     (stat_q),
   .timer_fire (timer_fire)
);

// File: tb/pdn_idle_detect_bench.sv
`timescale 1ns/1ps
module pdn_idle_detect_bench;
   localparam int NCH = 4;
   localparam int TA = 4;
   localparam int TB = 8;
   localparam int TC = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] irq_p = '1;
   logic [NCH-1:0] tx_i = '0;
   logic [NCH-1:0] rx_i = '0;
   logic [1:0]     code = 2'b00;
   logic           mask = 1'b1;
   logic           rd = 1'b0;
   logic           gp = 1'b0;
   logic           stat_bit;
   logic           pd_irq;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   pdn_idle_detect #(.NUM_CH(NCH), .TERM_A(TA), .TERM_B(TB), .TERM_C(TC)) u_pdn_idle_detect (
      .clk(clk), .rst_n(rst_n), .ch_irq_pend(irq_p), .ch_tx_idle(tx_i),
      .ch_rx_idle(rx_i), .filt_code(code), .irq_mask(mask), .status_rd(rd),
      .gp_in(gp), .stat_bit(stat_bit), .pd_irq(pd_irq)
   );

   // vector: {irq_pend, tx_idle, rx_idle, expect_set}
   localparam logic [12:0] VEC [10] = '{
      {4'h0, 4'hF, 4'hF, 1'b1},
      {4'h1, 4'hF, 4'hF, 1'b0},
      {4'h8, 4'hF, 4'hF, 1'b0},
      {4'h0, 4'hE, 4'hF, 1'b0},
      {4'h0, 4'h7, 4'hF, 1'b0},
      {4'h0, 4'hF, 4'hB, 1'b0},
      {4'h0, 4'hF, 4'hD, 1'b0},
      {4'h0, 4'hF, 4'hF, 1'b1},
      {4'h2, 4'hD, 4'h7, 1'b0},
      {4'h0, 4'hF, 4'hF, 1'b1}
   };

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go_busy();
      irq_p = '1; tx_i = '0; rx_i = '0;
   endtask

   task automatic go_quiet();
      irq_p = '0; tx_i = '1; rx_i = '1;
   endtask

   task automatic do_read();
      rd = 1'b1; wait_n(1); rd = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      wait_n(3);
      // reset state, feature off: shared bit shows the input pin (R7)
      gp = 1'b1;
      #0.1;
      chk("R7 reset gp shown", stat_bit, 1'b1);
      chk("R4 reset irq low", pd_irq, 1'b0);
      rst_n = 1'b1;
      wait_n(1);

      // vector table, code 01 (R1, R2)
      code = 2'b01;
      for (int i = 0; i < 10; i++) begin
         go_busy(); do_read(); wait_n(1);
         {irq_p, tx_i, rx_i} = VEC[i][12:1];
         wait_n(TA + 1);
         chk("R1/R2 vector stat", stat_bit, VEC[i][0]);
         chk("R1/R2 vector irq", pd_irq, VEC[i][0]);
      end

      // exact window edges per code (R3, R8)
      go_busy(); do_read(); wait_n(1);
      go_quiet(); wait_n(TA - 1);
      chk("R3 TA-1 edges", stat_bit, 1'b0);
      wait_n(1);
      chk("R3 TA edges", stat_bit, 1'b1);

      code = 2'b10; go_busy(); do_read(); wait_n(1);
      go_quiet(); wait_n(TB - 1);
      chk("R8 code10 TB-1", stat_bit, 1'b0);
      wait_n(1);
      chk("R8 code10 TB", stat_bit, 1'b1);

      code = 2'b11; go_busy(); do_read(); wait_n(1);
      go_quiet(); wait_n(TC - 1);
      chk("R8 code11 TC-1", stat_bit, 1'b0);
      wait_n(1);
      chk("R8 code11 TC", stat_bit, 1'b1);

      // activity mid-window restarts count (R3)
      code = 2'b01; go_busy(); do_read(); wait_n(1);
      go_quiet(); wait_n(TA - 1);
      rx_i[2] = 1'b0; wait_n(1);
      go_quiet(); wait_n(TA - 1);
      chk("R3 restart TA-1", stat_bit, 1'b0);
      wait_n(1);
      chk("R3 restart TA", stat_bit, 1'b1);

      // sticky through activity, then read clears (R5)
      go_busy(); wait_n(3);
      chk("R5 held after activity", stat_bit, 1'b1);
      do_read();
      chk("R5 cleared by read", stat_bit, 1'b0);

      // one request per quiet stretch (R10)
      go_quiet(); wait_n(TA);
      chk("R10 set once", stat_bit, 1'b1);
      do_read(); wait_n(2 * TA);
      chk("R10 no re-set while quiet", stat_bit, 1'b0);

      // mask gating (R6)
      go_busy(); wait_n(1); go_quiet(); mask = 1'b0; wait_n(TA);
      chk("R6 stat set", stat_bit, 1'b1);
      chk("R6 masked irq", pd_irq, 1'b0);
      mask = 1'b1; #0.1;
      chk("R6 unmasked irq", pd_irq, 1'b1);

      // read on the firing cycle keeps the bit (R9)
      go_busy(); do_read(); wait_n(1);
      go_quiet(); wait_n(TA - 1);
      rd = 1'b1; wait_n(1); rd = 1'b0;
      chk("R9 set beats clear", stat_bit, 1'b1);

      // disabled feature (R4, R7)
      code = 2'b00; go_busy(); wait_n(1); go_quiet(); gp = 1'b0;
      wait_n(4 * TC);
      chk("R4 off no irq", pd_irq, 1'b0);
      chk("R7 off shows gp 0", stat_bit, 1'b0);
      gp = 1'b1; #0.1;
      chk("R7 off shows gp 1", stat_bit, 1'b1);
      code = 2'b01; #0.1;
      chk("R4 no stale request on enable", stat_bit, 1'b0);

      summary();
      $finish;
   end
endmodule